// File: doc/BRIEF.md
# Sequence-Tagged Sampling Mailbox

A single-slot register link between one producer and one consumer that never stall each other. Each deposit overwrites the held word and advances a sequence stamp kept beside it. The consumer can look at the held word at any moment. It marks a word as taken by pulsing its read strobe, which copies the current stamp into a private "seen" register. The freshness flag is high whenever the stored stamp and the seen stamp disagree.

There is no valid/ack handshake. A producer that writes faster than the consumer reads simply replaces old words. A consumer that reads more often than the producer writes sees the same word again, with the freshness flag low. Both sides run on one clock here; any crossing between clock domains is handled outside this block.

Top module: `seq_mailbox`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rd_data` is 0 and `is_new` is 0.
- R2: A cycle with `wr_en` high stores `wr_data`, and from the next cycle `rd_data` shows that word.
- R3: Each write advances the stored stamp by one. A write that follows a read (with fewer than 2^TAG_W writes since that read) leaves `is_new` high from the next cycle.
- R4: A cycle with `rd_en` high and `wr_en` low leaves `is_new` low from the next cycle.
- R5: Reads never block. A read of a word already read returns that same word with `is_new` low, and the held word is unchanged.
- R6: When `rd_en` and `wr_en` are high in the same cycle, `rd_data` shows the previous word in that cycle. From the next cycle it shows the new word with `is_new` high.
- R7: The stamp is TAG_W bits wide and wraps modulo 2^TAG_W. After a read, 2^TAG_W-1 writes leave `is_new` high, and exactly 2^TAG_W writes make it read low.
- R8: Without a write, `rd_data` holds its whole value, so a word is never a mix of two writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Producer deposit strobe |
| wr_data | input | DATA_W | Word to deposit |
| rd_en | input | 1 | Consumer take strobe |
| rd_data | output | DATA_W | Currently held word |
| is_new | output | 1 | Held word not yet taken by the consumer |

## Verification
A deposit and a take can fall in the same cycle. This is the one case where the order inside the block decides what the consumer gets. The bench drives both strobes together, both right after a write and on a stale slot. It expects the old word during that cycle and the new word, flagged fresh, after the edge. A behavioural model that moves the seen stamp to the pre-write stamp judges every cycle, so any collision inside the random traffic is checked the same way.

// File: rtl/seq_mailbox.sv
module seq_mailbox #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              is_new
);

  logic [DATA_W-1:0] word_q;
  logic [TAG_W-1:0]  stamp_q;
  logic [TAG_W-1:0]  seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      stamp_q <= '0;
    end else if (wr_en) begin
      word_q  <= wr_data;
      stamp_q <= stamp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_q <= '0;
    else if (rd_en) seen_q <= stamp_q;
  end

  assign rd_data = word_q;
  assign is_new  = (stamp_q != seen_q);

endmodule

// File: rtl/seq_mailbox_chk.sv
module seq_mailbox_chk #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              is_new,
  input logic [TAG_W-1:0]  stamp_q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!is_new && rd_data == '0));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  // R3
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> stamp_q == TAG_W'($past(stamp_q) + 1'b1));

  // R4
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> !is_new);

  // R6
  collide_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> is_new);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

endmodule

bind seq_mailbox seq_mailbox_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .rd_data(rd_data), .is_new(is_new), .stamp_q(stamp_q)
);

// File: tb/tb_seq_mailbox.sv
module tb_seq_mailbox;
  localparam int DW = 32;
  localparam int TW = 8;
  localparam int WRAP = 1 << TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic is_new;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [DW-1:0] m_word;
  int m_stamp;
  int m_seen;

  always #4 clk = ~clk;

  seq_mailbox #(.DATA_W(DW), .TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .is_new(is_new)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = '0; m_stamp = 0; m_seen = 0;
    end else begin
      int old_stamp;
      old_stamp = m_stamp;
      if (wr_en) begin
        m_word = wr_data;
        m_stamp = (m_stamp + 1) % WRAP;
      end
      if (rd_en) m_seen = old_stamp;
    end
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(cur_req, rd_data, m_word);
    chk(cur_req, DW'(is_new), DW'(m_stamp != m_seen));
  end

  task automatic op(bit w, bit r, logic [DW-1:0] d);
    wr_en = w; rd_en = r; wr_data = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] seed;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", DW'(is_new), 0);
    chk("R1", rd_data, 0);
    rst_n = 1'b1;
    op(0, 0, 0);
    chk("R1", DW'(is_new), 0);

    cur_req = "R2"; op(1, 0, 32'hA5A5_0001);
    chk("R2", rd_data, 32'hA5A5_0001);
    chk("R3", DW'(is_new), 1);
    cur_req = "R8"; op(0, 0, 32'hFFFF_FFFF); op(0, 0, 32'h0);
    chk("R8", rd_data, 32'hA5A5_0001);
    cur_req = "R4"; op(0, 1, 0);
    chk("R4", DW'(is_new), 0);
    cur_req = "R5"; op(0, 1, 32'h1111_1111);
    chk("R5", rd_data, 32'hA5A5_0001);
    chk("R5", DW'(is_new), 0);

    cur_req = "R6";
    wr_en = 1; rd_en = 1; wr_data = 32'hBEEF_0002;
    #1 chk("R6", rd_data, 32'hA5A5_0001);
    @(negedge clk);
    chk("R6", rd_data, 32'hBEEF_0002);
    chk("R6", DW'(is_new), 1);
    op(1, 1, 32'hC0DE_0003);
    chk("R6", DW'(is_new), 1);
    op(0, 1, 0);
    chk("R4", DW'(is_new), 0);

    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      op(seed[20], seed[27], seed);
    end

    cur_req = "R7";
    op(0, 1, 0);
    for (int i = 0; i < WRAP - 1; i++) op(1, 0, DW'(i + 100));
    chk("R7", DW'(is_new), 1);
    op(1, 0, 32'h7777_7777);
    chk("R7", DW'(is_new), 0);
    chk("R7", rd_data, 32'h7777_7777);
    op(0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule